// File: doc/BRIEF.md
# Sequential FIR Tap Engine

This block produces one output sample of a 16-tap FIR filter each time it is started. It steps through the taps one after another. For each tap it drives an address to a 16-entry circular sample store and an address to a coefficient store. It hands both operands to an external start/busy sequential multiplier and adds the returned product into a running sum. Samples arrive in two's complement and are converted to sign-magnitude for the multiplier. Coefficients arrive already in sign-magnitude. Each product comes back in sign-magnitude and is converted back to two's complement before it is added.

The caller pulses `start_i` with the slot index of the sample that is still being acquired. The newest usable sample therefore sits one slot below that index, and older samples lie further below it, modulo 16. A 4-bit filter select picks one of sixteen coefficient sets. When `busy_o` falls, `result_o` holds the sum divided by 128, which is the top 8 bits of the 15-bit accumulator.

The controller has five states. `ST_IDLE` moves to `ST_ADDR` on start. `ST_ADDR` moves to `ST_MSTART` after one cycle. `ST_MSTART` moves to `ST_MWAIT` once the multiplier reports busy. `ST_MWAIT` moves back to `ST_ADDR` when the product is ready and more taps remain, or to `ST_OUT` after the last tap. `ST_OUT` moves to `ST_IDLE` after one cycle.

Top module: `fir_tap_engine`

## Requirements
- R1: After reset, `busy_o` is 0, `mul_start_o` is 0 and `result_o` is 0.
- R2: A start pulse while idle captures `base_i` and `filt_sel_i`, and `busy_o` is 1 from the next cycle until the result is valid. While busy, a start pulse and any change of `base_i` or `filt_sel_i` have no effect on the addresses, the tap count or the result.
- R3: For tap k (k = 0..15, in increasing order), `ram_addr_o` equals (base − k − 1) mod 16 and `rom_addr_o` equals {select, k}, with the select in the upper 4 bits. Both addresses hold steady while the multiplier start is requested.
- R4: `mul_start_o` is raised only while busy, one cycle after the addresses for a tap appear. It stays high until `mul_busy_i` is seen high. Exactly 16 multiplications are started per run.
- R5: `mul_b_o` is the sign-magnitude form of the sample: bit 7 is the sign and bits 6:0 the magnitude. The sample −128 maps to −127 (0xFF), and the conversion never produces sign 1 with magnitude 0. `mul_a_o` passes the coefficient through unchanged.
- R6: A product from the multiplier (bit 14 sign, bits 13:0 magnitude) is added as a two's-complement value. A product with sign 1 and magnitude 0 adds 0.
- R7: Products are summed modulo 2^15, and `result_o` is bits 14:7 of the final sum.
- R8: `busy_o` falls two cycles after `mul_busy_i` falls for the last tap (one cycle in `ST_OUT`). `result_o` changes only on that edge and then holds while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin one output computation |
| base_i | input | 4 | Slot of the sample being acquired |
| filt_sel_i | input | 4 | Coefficient set select |
| busy_o | output | 1 | Computation in progress |
| result_o | output | 8 | Scaled filter output, two's complement |
| ram_addr_o | output | 4 | Sample store address |
| rom_addr_o | output | 8 | Coefficient store address {select, tap} |
| ram_data_i | input | 8 | Sample, two's complement |
| rom_data_i | input | 8 | Coefficient, sign-magnitude |
| mul_start_o | output | 1 | Multiplier start request |
| mul_busy_i | input | 1 | Multiplier busy |
| mul_a_o | output | 8 | Multiplier operand A (coefficient, sign-magnitude) |
| mul_b_o | output | 8 | Multiplier operand B (sample, sign-magnitude) |
| mul_prod_i | input | 15 | Product, sign-magnitude |

## Verification
Some internal faults show up in the first multiplier request after start: a tap counter off by one, or a wrong offset in the circular address. The sample address or operand B is then wrong on that request, long before the result appears. A skipped or repeated tap changes the number of multiplier starts and shifts when `busy_o` falls relative to the last product. A faulty sign conversion, including the minus-zero case, or a wrong accumulator slice reaches the ports only through `result_o` at the end of the run. The bench compares that value with a sum computed independently over the modelled stores.

// File: rtl/fir_pkg.sv
package fir_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_MSTART,
        ST_MWAIT,
        ST_OUT
    } fir_state_t;
endpackage

// File: rtl/fir_tc2sm.sv
// Two's complement to sign-magnitude; the most negative code saturates.
module fir_tc2sm #(
    parameter int W = 8
) (
    input  logic [W-1:0] tc_i,
    output logic [W-1:0] sm_o
);
    logic [W-2:0] neg_mag;

    always_comb begin
        neg_mag = (~tc_i[W-2:0]) + {{(W-2){1'b0}}, 1'b1};
        if (!tc_i[W-1]) begin
            sm_o = tc_i;
        end else if (neg_mag == '0) begin
            sm_o = {1'b1, {(W-1){1'b1}}};
        end else begin
            sm_o = {1'b1, neg_mag};
        end
    end

    always_comb begin
        AST_NO_NEG_ZERO: assert (!(sm_o[W-1] && sm_o[W-2:0] == '0)); // R5
    end
endmodule

// File: rtl/fir_sm2tc.sv
// Sign-magnitude to two's complement; minus zero yields zero.
module fir_sm2tc #(
    parameter int W = 15
) (
    input  logic [W-1:0] sm_i,
    output logic [W-1:0] tc_o
);
    logic [W-1:0] mag;

    always_comb begin
        mag = {1'b0, sm_i[W-2:0]};
        if (sm_i[W-1] && (mag != '0)) begin
            tc_o = (~mag) + {{(W-1){1'b0}}, 1'b1};
        end else begin
            tc_o = mag;
        end
    end
endmodule

// File: rtl/fir_addr_gen.sv
// Circular sample address behind the base slot, and coefficient address.
module fir_addr_gen #(
    parameter int TAP_W = 4,
    parameter int SEL_W = 4
) (
    input  logic [TAP_W-1:0]       base_i,
    input  logic [TAP_W-1:0]       tap_i,
    input  logic [SEL_W-1:0]       sel_i,
    output logic [TAP_W-1:0]       ram_addr_o,
    output logic [SEL_W+TAP_W-1:0] rom_addr_o
);
    logic [TAP_W-1:0] back_off;

    always_comb begin
        back_off   = tap_i + {{(TAP_W-1){1'b0}}, 1'b1};
        ram_addr_o = base_i - back_off;
        rom_addr_o = {sel_i, tap_i};
    end
endmodule

// File: rtl/fir_tap_engine.sv
module fir_tap_engine
    import fir_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TAPS   = 16,
    parameter int SEL_W  = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start_i,
    input  logic [$clog2(TAPS)-1:0]                base_i,
    input  logic [SEL_W-1:0]                       filt_sel_i,
    output logic                                   busy_o,
    output logic [DATA_W-1:0]                      result_o,
    output logic [$clog2(TAPS)-1:0]                ram_addr_o,
    output logic [SEL_W+$clog2(TAPS)-1:0]          rom_addr_o,
    input  logic [DATA_W-1:0]                      ram_data_i,
    input  logic [DATA_W-1:0]                      rom_data_i,
    output logic                                   mul_start_o,
    input  logic                                   mul_busy_i,
    output logic [DATA_W-1:0]                      mul_a_o,
    output logic [DATA_W-1:0]                      mul_b_o,
    input  logic [2*DATA_W-2:0]                    mul_prod_i
);
    localparam int TAP_W  = $clog2(TAPS);
    localparam int PROD_W = 2 * DATA_W - 1;
    localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(TAPS - 1);

    fir_state_t        state_q, state_d;
    logic [TAP_W-1:0]  tap_q;
    logic [TAP_W-1:0]  base_q;
    logic [SEL_W-1:0]  sel_q;
    logic [PROD_W-1:0] acc_q;
    logic [PROD_W-1:0] prod_tc;
    logic [DATA_W-1:0] result_q;

    // Address generation
    fir_addr_gen #(
        .TAP_W (TAP_W),
        .SEL_W (SEL_W)
    ) u_addr (
        .base_i     (base_q),
        .tap_i      (tap_q),
        .sel_i      (sel_q),
        .ram_addr_o (ram_addr_o),
        .rom_addr_o (rom_addr_o)
    );

    // Sample into sign-magnitude for the multiplier
    fir_tc2sm #(.W(DATA_W)) u_smp_conv (
        .tc_i (ram_data_i),
        .sm_o (mul_b_o)
    );

    // Product back into two's complement
    fir_sm2tc #(.W(PROD_W)) u_prod_conv (
        .sm_i (mul_prod_i),
        .tc_o (prod_tc)
    );

    assign mul_a_o  = rom_data_i;
    assign result_o = result_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_ADDR;
            ST_ADDR:   state_d = ST_MSTART;
            ST_MSTART: if (mul_busy_i) state_d = ST_MWAIT;
            ST_MWAIT: begin
                if (!mul_busy_i) begin
                    state_d = (tap_q == LAST_TAP) ? ST_OUT : ST_ADDR;
                end
            end
            ST_OUT:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from state
    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        mul_start_o = (state_q == ST_MSTART);
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_q    <= '0;
            base_q   <= '0;
            sel_q    <= '0;
            acc_q    <= '0;
            result_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        base_q <= base_i;
                        sel_q  <= filt_sel_i;
                        tap_q  <= '0;
                        acc_q  <= '0;
                    end
                end
                ST_MWAIT: begin
                    if (!mul_busy_i) begin
                        acc_q <= acc_q + prod_tc;
                        if (tap_q != LAST_TAP) begin
                            tap_q <= tap_q + {{(TAP_W-1){1'b0}}, 1'b1};
                        end
                    end
                end
                ST_OUT: begin
                    result_q <= acc_q[PROD_W-1 -: DATA_W];
                end
                default: ;
            endcase
        end
    end

    // Assertions
    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mul_start_o |-> busy_o); // R4
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o); // R2
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_start_o && $past(mul_start_o)) |-> ($stable(ram_addr_o) && $stable(rom_addr_o))); // R3
    AST_IDLE_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o)) |-> $stable(result_o)); // R8
    AST_OUT_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OUT) |=> !busy_o); // R8
endmodule

// File: tb/tb_fir_tap_engine.sv
module tb_fir_tap_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  base_i = '0;
    logic [3:0]  filt_sel_i = '0;
    logic        busy_o;
    logic [7:0]  result_o;
    logic [3:0]  ram_addr_o;
    logic [7:0]  rom_addr_o;
    logic [7:0]  ram_data_i;
    logic [7:0]  rom_data_i;
    logic        mul_start_o;
    logic        mul_busy_i;
    logic [7:0]  mul_a_o;
    logic [7:0]  mul_b_o;
    logic [14:0] mul_prod_i;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0] ram_mem [16];
    logic [7:0] exp_q [$];
    logic [3:0] cur_base = '0;
    logic [3:0] cur_sel  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fir_tap_engine dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .base_i      (base_i),
        .filt_sel_i  (filt_sel_i),
        .busy_o      (busy_o),
        .result_o    (result_o),
        .ram_addr_o  (ram_addr_o),
        .rom_addr_o  (rom_addr_o),
        .ram_data_i  (ram_data_i),
        .rom_data_i  (rom_data_i),
        .mul_start_o (mul_start_o),
        .mul_busy_i  (mul_busy_i),
        .mul_a_o     (mul_a_o),
        .mul_b_o     (mul_b_o),
        .mul_prod_i  (mul_prod_i)
    );

    // Coefficient store contents, sign-magnitude
    function automatic logic [7:0] coef(logic [3:0] sel, logic [3:0] k);
        case (sel)
            4'd0:    return (k == 0) ? 8'h7F : 8'h00;
            4'd1:    return (k == 0) ? 8'hFF : 8'h00;
            4'd2:    return 8'h08;
            4'd3:    return 8'h80;
            4'd4:    return 8'h7F;
            default: return 8'((int'(sel) * 53 + int'(k) * 29 + 7) % 256);
        endcase
    endfunction

    function automatic logic [7:0] to_sm(logic [7:0] v);
        int s;
        s = int'($signed(v));
        if (s == -128) s = -127;
        return (s < 0) ? {1'b1, 7'(-s)} : {1'b0, 7'(s)};
    endfunction

    function automatic logic [7:0] golden(logic [3:0] b, logic [3:0] sel);
        int acc = 0;
        for (int k = 0; k < 16; k++) begin
            logic [3:0] a;
            logic [7:0] c;
            int s, cv;
            a = b - 4'(k) - 4'd1;
            s = int'($signed(ram_mem[a]));
            if (s == -128) s = -127;
            c = coef(sel, 4'(k));
            cv = c[7] ? -int'(c[6:0]) : int'(c[6:0]);
            acc += s * cv;
        end
        return 8'((acc & 32767) >> 7);
    endfunction

    assign ram_data_i = ram_mem[ram_addr_o];
    assign rom_data_i = coef(rom_addr_o[7:4], rom_addr_o[3:0]);

    // Sequential multiplier model: eight busy cycles, sign-magnitude product
    logic [7:0]  m_a, m_b;
    logic [3:0]  m_cnt;
    logic        m_busy;
    logic [14:0] m_prod;
    assign mul_busy_i = m_busy;
    assign mul_prod_i = m_prod;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0;
            m_cnt  <= '0;
            m_prod <= '0;
            m_a    <= '0;
            m_b    <= '0;
        end else if (!m_busy && mul_start_o) begin
            m_busy <= 1'b1;
            m_cnt  <= 4'd8;
            m_a    <= mul_a_o;
            m_b    <= mul_b_o;
        end else if (m_busy) begin
            if (m_cnt == 4'd1) begin
                m_busy <= 1'b0;
                m_prod <= {m_a[7] ^ m_b[7], 14'(m_a[6:0] * m_b[6:0])};
            end
            m_cnt <= m_cnt - 4'd1;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: per-tap operand/address checks and result scoreboard
    int  taps = 0;
    int  since_mfall = -1;
    bit  prev_busy = 0;
    bit  prev_mbusy = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mul_start_o && !m_busy) begin
                check(ram_addr_o == 4'(cur_base - 4'(taps) - 4'd1), "R3 ram address",
                      int'(ram_addr_o), int'(4'(cur_base - 4'(taps) - 4'd1)));
                check(rom_addr_o == {cur_sel, 4'(taps)}, "R3 rom address",
                      int'(rom_addr_o), int'({cur_sel, 4'(taps)}));
                check(mul_b_o == to_sm(ram_data_i), "R5 sample conversion",
                      int'(mul_b_o), int'(to_sm(ram_data_i)));
                check(mul_a_o == rom_data_i, "R5 coefficient pass", int'(mul_a_o), int'(rom_data_i));
                taps++;
            end
            if (prev_mbusy && !m_busy) since_mfall = 0;
            else if (since_mfall >= 0) since_mfall++;
            if (prev_busy && !busy_o) begin
                check(exp_q.size() > 0, "R2 unexpected result", exp_q.size(), 1);
                if (exp_q.size() > 0) begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(result_o == e, "R7 result", int'(result_o), int'(e));
                end
                check(taps == 16, "R4 tap count", taps, 16);
                check(since_mfall == 2, "R8 busy fall delay", since_mfall, 2);
                taps = 0;
                since_mfall = -1;
            end
            prev_busy  = busy_o;
            prev_mbusy = m_busy;
        end
    end

    // Driver
    task automatic run(logic [3:0] b, logic [3:0] sel, bit noise);
        logic [7:0] held;
        exp_q.push_back(golden(b, sel));
        cur_base = b;
        cur_sel  = sel;
        @(negedge clk);
        start_i    = 1'b1;
        base_i     = b;
        filt_sel_i = sel;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
        if (noise) begin
            repeat (20) @(negedge clk);
            start_i    = 1'b1;
            base_i     = b + 4'd5;
            filt_sel_i = sel + 4'd3;
            @(negedge clk);
            start_i = 1'b0;
            repeat (40) @(negedge clk);
            base_i     = b + 4'd9;
            filt_sel_i = ~sel;
        end
        while (busy_o) @(negedge clk);
        held = result_o;
        repeat (4) @(negedge clk);
        check(result_o == held && !busy_o, "R8 result hold", int'(result_o), int'(held));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        check(1'b0, "watchdog", 0, 1);
        if (!finished) begin
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < 16; j++) ram_mem[j] = 8'((j * 37 + 11) % 256);
        ram_mem[3] = 8'h80;
        repeat (3) @(negedge clk);
        check(busy_o == 0, "R1 busy reset", int'(busy_o), 0);
        check(mul_start_o == 0, "R1 mul start reset", int'(mul_start_o), 0);
        check(result_o == 0, "R1 result reset", int'(result_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run(4'd5, 4'd0, 0);   // single positive tap
        run(4'd5, 4'd1, 0);   // single negative tap
        run(4'd0, 4'd2, 0);   // flat taps, base 0 wraps
        run(4'd4, 4'd2, 0);   // -128 sample saturates (R5)
        run(4'd15, 4'd3, 0);  // minus-zero coefficients give 0 (R6)
        for (int j = 5; j < 16; j++) run(4'(j * 7), 4'(j), 0);
        run(4'd9, 4'd7, 1);   // inputs and start changed while busy (R2)

        for (int j = 0; j < 16; j++) ram_mem[j] = 8'h00;
        run(4'd2, 4'd1, 0);   // zero samples with negative tap: minus-zero products (R6)
        for (int j = 0; j < 16; j++) ram_mem[j] = 8'h7F;
        run(4'd11, 4'd4, 0);  // accumulator wraps modulo 2^15 (R7)

        check(exp_q.size() == 0, "R2 pending results", exp_q.size(), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule